// File: doc/BRIEF.md
# Opcode-Fetch Character Video Generator

This block sits between a CPU, its program memory and a video output, and turns ordinary opcode fetches into a character display. Display data lives in memory as a stream of character codes that the CPU "executes". When such a code is fetched from the upper half of the address space, the block hands the CPU a NOP instead, so the CPU simply runs through the line. In the refresh half of that same M1 cycle, the block points the memory address bus at a character-pattern address. That address is built from three parts: the fetched code, the current scanline within the character row, and the high byte of the refresh address, which carries the I register. The pattern byte that comes back is latched, inverted when the code asks for it, and shifted out two pixels per clock. A full byte therefore lasts exactly the four clocks of one M1 cycle.

The block also raises an interrupt request whenever the refresh address of an opcode fetch has bit 6 low. The host uses this to mark the end of a display line. The CPU, the memory contents and the sync timing are outside the block. The scanline counter and the sync state arrive as inputs, and the memory is a combinational read on `mem_addr` / `mem_data`.

Top module: `opfetch_vidgen`

## Requirements
- R1: In a cycle with `fetch_valid`=1, if `cpu_addr[15]`=1 and `mem_data[6]`=0 (a video fetch), `cpu_data` is 8'h00. In every other case `cpu_data` equals `mem_data`.
- R2: In a cycle with `fetch_valid`=1, `mem_addr` equals `cpu_addr` with bit 15 forced to 0.
- R3: In the first `refresh_valid` cycle after a video fetch, `mem_addr` = {`rfsh_addr[15:9]`, fetched byte bits [5:0], `line_cnt[2:0]`}. In a refresh cycle that follows a non-video fetch, `mem_addr` equals `rfsh_addr`.
- R4: At the clock edge that ends that refresh cycle, the pattern byte on `mem_data` is loaded into the pixel shifter. It is complemented when bit 7 of the fetched byte was 1.
- R5: During the four clocks after the load, `pix` carries the loaded byte's bits [7:6], [5:4], [3:2] and then [1:0]. `pix[1]` is the earlier pixel on screen, so the byte is sent MSB first.
- R6: When no byte has been loaded for the current four-clock slot, `pix` is 2'b00. This covers the clock after the four pixel clocks and every slot that follows a non-video fetch.
- R7: While `sync_active`=1, no pattern byte is loaded and `pix` is 2'b00.
- R8: After each `refresh_valid` cycle, `irq` equals the inverse of that cycle's `rfsh_addr[6]`. `irq` keeps that value until the next refresh cycle.
- R9: After reset, `irq`=0, `pix`=2'b00, and no video fetch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| fetch_valid | input | 1 | Opcode-read half of an M1 cycle |
| refresh_valid | input | 1 | Refresh half of an M1 cycle |
| cpu_addr | input | 16 | CPU address during the opcode read |
| rfsh_addr | input | 16 | Refresh address; upper byte is the I register |
| line_cnt | input | 3 | Scanline within the character row |
| sync_active | input | 1 | Sync state from the sync generator |
| mem_data | input | 8 | Data read from memory at `mem_addr` |
| mem_addr | output | 16 | Address presented to memory |
| cpu_data | output | 8 | Data returned to the CPU |
| pix | output | 2 | Two pixels per clock; bit 1 first |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `fetch_valid` and `refresh_valid` never rise in the same cycle, and that a refresh cycle always follows its fetch cycle directly. They also assume that `line_cnt` and `sync_active` stay steady across one M1 cycle. The stimulus meets these assumptions by construction: it runs every M1 cycle as one fetch clock, one refresh clock and four idle clocks. It changes the random address, refresh, scanline and sync values only at the start of each such group.

// File: rtl/vidgen_pkg.sv
package vidgen_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned LCNT_W      = 3;
  localparam int unsigned CHAR_W      = 6;
  localparam int unsigned PIX_PER_CLK = 2;
  localparam int unsigned QUAL_BIT    = 6;  // fetched bit that must be 0 for video
  localparam int unsigned INV_BIT     = 7;  // fetched bit that requests inversion
  localparam int unsigned IRQ_BIT     = 6;  // refresh address bit that requests irq
  localparam logic [DATA_W-1:0] NOP_OP = '0;

  typedef struct packed {
    logic              pend;
    logic [DATA_W-1:0] code;
  } fetch_state_t;
endpackage

// File: rtl/vg_fetch.sv
module vg_fetch
  import vidgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              refresh_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] cpu_data,
  output fetch_state_t      st
);
  logic         qual;
  fetch_state_t st_n;

  assign qual = fetch_valid & cpu_addr[ADDR_W-1] & ~mem_data[QUAL_BIT];

  always_comb begin
    cpu_data = qual ? NOP_OP : mem_data;
  end

  always_comb begin
    st_n = st;
    if (fetch_valid) begin
      st_n.pend = qual;
      st_n.code = mem_data;
    end else if (refresh_valid) begin
      st_n.pend = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= st_n;
  end

  // R1: a video fetch leaves a pending slot for the refresh cycle
  a_r1_qual_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && cpu_addr[ADDR_W-1] && !mem_data[QUAL_BIT]) |=> st.pend);
  // R9: a refresh always consumes the pending slot
  a_r9_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_valid && !fetch_valid) |=> !st.pend);
endmodule

// File: rtl/vg_addr.sv
module vg_addr
  import vidgen_pkg::*;
(
  input  logic              fetch_valid,
  input  logic              refresh_valid,
  input  logic              pend,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] rfsh_addr,
  input  logic [CHAR_W-1:0] code,
  input  logic [LCNT_W-1:0] line_cnt,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int unsigned IHI_W = ADDR_W - CHAR_W - LCNT_W;

  logic [ADDR_W-1:0] pat_addr;
  logic [ADDR_W-1:0] low_addr;

  assign pat_addr = {rfsh_addr[ADDR_W-1 -: IHI_W], code, line_cnt};
  assign low_addr = {1'b0, cpu_addr[ADDR_W-2:0]};

  always_comb begin
    if (fetch_valid)                mem_addr = low_addr;
    else if (refresh_valid && pend) mem_addr = pat_addr;
    else if (refresh_valid)         mem_addr = rfsh_addr;
    else                            mem_addr = low_addr;
  end
endmodule

// File: rtl/vg_shifter.sv
module vg_shifter
  import vidgen_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [DATA_W-1:0]      din,
  input  logic                   blank,
  output logic [PIX_PER_CLK-1:0] pix
);
  localparam int unsigned SLOT_CLKS = DATA_W / PIX_PER_CLK;
  localparam int unsigned CNT_W     = $clog2(SLOT_CLKS + 1);

  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              live;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (load) begin
      sh_n  = din;
      cnt_n = CNT_W'(SLOT_CLKS);
    end else if (cnt_q != '0) begin
      sh_n  = sh_q << PIX_PER_CLK;
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign live = (cnt_q != '0) && !blank;

  for (genvar i = 0; i < PIX_PER_CLK; i++) begin : g_lane
    assign pix[PIX_PER_CLK-1-i] = live & sh_q[DATA_W-1-i];
  end

  // R5: a load opens a full slot of pixel clocks
  a_r5_slot_len: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == CNT_W'(SLOT_CLKS)));
  // R6: without reload the slot runs down by one per clock
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/vg_irq.sv
module vg_irq
  import vidgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_valid,
  input  logic [ADDR_W-1:0] rfsh_addr,
  output logic              irq
);
  logic irq_n;
  logic up_q;

  always_comb begin
    irq_n = irq;
    if (refresh_valid) irq_n = ~rfsh_addr[IRQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      up_q <= 1'b0;
    end else begin
      irq  <= irq_n;
      up_q <= 1'b1;
    end
  end

  // R8: irq follows the last refresh address bit
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(refresh_valid)) |-> (irq == !$past(rfsh_addr[IRQ_BIT])));
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(refresh_valid)) |-> $stable(irq));
endmodule

// File: rtl/opfetch_vidgen.sv
module opfetch_vidgen
  import vidgen_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic                   refresh_valid,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [ADDR_W-1:0]      rfsh_addr,
  input  logic [LCNT_W-1:0]      line_cnt,
  input  logic                   sync_active,
  input  logic [DATA_W-1:0]      mem_data,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      cpu_data,
  output logic [PIX_PER_CLK-1:0] pix,
  output logic                   irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  fetch_state_t      fst;
  logic              load;
  logic [DATA_W-1:0] pat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  vg_fetch u_fetch (
    .clk(clk), .rst_n(rst_int_n), .fetch_valid(fetch_valid),
    .refresh_valid(refresh_valid), .cpu_addr(cpu_addr),
    .mem_data(mem_data), .cpu_data(cpu_data), .st(fst)
  );

  vg_addr u_addr (
    .fetch_valid(fetch_valid), .refresh_valid(refresh_valid), .pend(fst.pend),
    .cpu_addr(cpu_addr), .rfsh_addr(rfsh_addr), .code(fst.code[CHAR_W-1:0]),
    .line_cnt(line_cnt), .mem_addr(mem_addr)
  );

  assign load     = refresh_valid & fst.pend & ~sync_active;
  assign pat_byte = mem_data ^ {DATA_W{fst.code[INV_BIT]}};

  vg_shifter u_shift (
    .clk(clk), .rst_n(rst_int_n), .load(load), .din(pat_byte),
    .blank(sync_active), .pix(pix)
  );

  vg_irq u_irq (
    .clk(clk), .rst_n(rst_int_n), .refresh_valid(refresh_valid),
    .rfsh_addr(rfsh_addr), .irq(irq)
  );

  // R2: the memory never sees A15 during an opcode read
  a_r2_fetch_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    fetch_valid |-> !mem_addr[ADDR_W-1]);
  // R3: a pattern read carries the scanline in its low bits
  a_r3_line_bits: assert property (@(posedge clk) disable iff (!rst_int_n)
    (refresh_valid && fst.pend) |-> (mem_addr[LCNT_W-1:0] == line_cnt));
  // R7: sync blanks the pixels
  a_r7_sync_black: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_active |-> (pix == '0));
  // R4: a load only follows a video fetch in the previous clock
  a_r4_load_after_fetch: assert property (@(posedge clk) disable iff (!rst_int_n)
    load |-> ($past(fetch_valid) && $past(cpu_addr[ADDR_W-1])));
endmodule

// File: tb/sim_opfetch_vidgen.sv
module sim_opfetch_vidgen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, refresh_valid, sync_active, irq;
  logic [15:0] cpu_addr, rfsh_addr, mem_addr;
  logic [2:0]  line_cnt;
  logic [7:0]  mem_data, cpu_data;
  logic [1:0]  pix;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    logic [7:0] h;
    h = a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h5A;
    return h ^ {h[3:0], h[7:4]};
  endfunction

  assign mem_data = rom_byte(mem_addr);

  opfetch_vidgen u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .refresh_valid(refresh_valid), .cpu_addr(cpu_addr), .rfsh_addr(rfsh_addr),
    .line_cnt(line_cnt), .sync_active(sync_active), .mem_data(mem_data),
    .mem_addr(mem_addr), .cpu_data(cpu_data), .pix(pix), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m1(input logic [15:0] a, input logic [15:0] r,
                    input logic [2:0] lc, input logic sy);
    logic [7:0]  d, pb;
    logic        vid;
    logic [15:0] pa;
    d   = rom_byte({1'b0, a[14:0]});
    vid = a[15] && !d[6];
    pa  = {r[15:9], d[5:0], lc};
    pb  = rom_byte(pa) ^ (d[7] ? 8'hFF : 8'h00);
    @(negedge clk);
    fetch_valid = 1'b1; cpu_addr = a; line_cnt = lc; sync_active = sy;
    #3;
    chk("R1 cpu_data", cpu_data, vid ? 8'h00 : d);
    chk("R2 fetch addr", mem_addr, {1'b0, a[14:0]});
    @(negedge clk);
    fetch_valid = 1'b0; refresh_valid = 1'b1; rfsh_addr = r;
    #3;
    chk("R3 refresh addr", mem_addr, vid ? pa : r);
    @(negedge clk);
    refresh_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #3;
      if (vid && !sy) chk("R4 R5 pixels", pix, 2'((pb >> (6 - 2*k)) & 8'h3));
      else if (sy)    chk("R7 sync black", pix, 2'b00);
      else            chk("R6 no byte", pix, 2'b00);
      chk("R8 irq", irq, !r[6]);
      @(negedge clk);
    end
    #3;
    chk("R6 slot over", pix, 2'b00);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [15:0] r;
    logic [15:0] found;
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; fetch_valid = 1'b0; refresh_valid = 1'b0;
    cpu_addr = '0; rfsh_addr = '0; line_cnt = '0; sync_active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    chk("R9 reset pix", pix, 2'b00);
    chk("R9 reset irq", irq, 1'b0);
    // R9: refresh right after reset does not redirect the address
    refresh_valid = 1'b1; rfsh_addr = 16'h1234;
    #1;
    chk("R9 no pending", mem_addr, 16'h1234);
    @(negedge clk);
    refresh_valid = 1'b0;
    // directed: search a video code with inversion and one without
    found = 16'h8000;
    for (int i = 0; i < 4096; i++) begin
      a = 16'h8000 | 16'(i);
      if (!rom_byte({1'b0, a[14:0]})[6] && rom_byte({1'b0, a[14:0]})[7]) begin
        found = a;
        break;
      end
    end
    m1(found, 16'h3E00, 3'd5, 1'b0);   // R4 inverted
    for (int i = 0; i < 4096; i++) begin
      a = 16'h8000 | 16'(i);
      if (!rom_byte({1'b0, a[14:0]})[6] && !rom_byte({1'b0, a[14:0]})[7]) begin
        found = a;
        break;
      end
    end
    m1(found, 16'hFE40, 3'd7, 1'b0);   // R4 plain, R8 bit6=1
    m1(found, 16'h0000, 3'd0, 1'b1);   // R7 sync suppresses load
    m1(found & 16'h7FFF, 16'h2200, 3'd2, 1'b0); // R1 low half passes data
    // random mix
    for (int n = 0; n < 300; n++) begin
      a = 16'($urandom);
      r = 16'($urandom);
      m1(a, r, 3'($urandom), ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule